// File: doc/BRIEF.md
# Posted Memory Write Packetizer

This block turns a single write command into one posted memory write request packet. A command holds a 64-bit byte address, one 32-bit data word and four byte-enable bits. The block sends the packet as a stream of 32-bit words on a valid/ready output. A flag marks the final word of each packet.

The address decides the header size for each command. If the upper 32 address bits are all zero, the block sends a three-word header. Otherwise it sends a four-word header that carries both address halves. Exactly one payload word always follows the header. The request is posted, so the block waits for no response. It returns to idle as soon as the payload word is taken downstream. It accepts no new command while a packet is being sent.

Each header carries a fixed requester identity, which is set by a parameter. It also carries an 8-bit tag that advances by one for every packet sent.

Top module: `mwr_packetizer`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` and `out_last` are 0 and `cmd_ready` is 1.
- R2: `cmd_ready` is 0 in every cycle in which `out_valid` is 1. A command offered during that time is not taken and does not alter the packet being sent.
- R3: When `cmd_addr[63:32]` is zero, the packet has four words: two header words, then the address word, then the payload.
- R4: When `cmd_addr[63:32]` is non-zero, the packet has five words. The third word is `cmd_addr[63:32]`, the fourth is the low address word, and the payload comes last.
- R5: The first word is laid out as follows. Bit 31 is 0. Bits [30:29] hold the format: 2'b10 for the short header, 2'b11 for the long one. Bits [28:24] hold the type, which is 5'b00000. Bits [23:10] are zero. Bits [9:0] hold the length, which is 1.
- R6: The second word is laid out as follows. Bits [31:16] hold the requester ID parameter. Bits [15:8] hold the tag. Bits [7:4] are 4'b0000. Bits [3:0] hold `cmd_be`.
- R7: The tag is 0 for the first packet after reset. It rises by one, wrapping from 255 to 0, for each packet that has been fully sent.
- R8: Every packet ends with exactly one payload word equal to `cmd_data`. `out_last` is 1 on that word and on no other word.
- R9: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid`, `out_data` and `out_last` unchanged.
- R10: The first word is valid in the cycle after the command is accepted. In the cycle after the last word is accepted, `out_valid` is 0 and `cmd_ready` is 1.
- R11: The low address word is `cmd_addr[31:2]` followed by 2'b00. Address bits [1:0] never appear in the packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | A write command is offered |
| cmd_ready | output | 1 | Block is idle and takes the offered command |
| cmd_addr | input | 64 | Target byte address |
| cmd_data | input | 32 | Payload word |
| cmd_be | input | 4 | Byte enables of the payload word |
| out_valid | output | 1 | `out_data` holds a packet word |
| out_ready | input | 1 | Downstream takes the current word |
| out_data | output | 32 | Packet word |
| out_last | output | 1 | Current word is the final word of the packet |

## Verification
Two events can fall in the same cycle: the final payload word being accepted and a new command waiting at the input. The bench provokes this by raising `cmd_valid` with the next command while the previous packet is still being sent. It does this both with `out_ready` held high and with `out_ready` driven by a pseudo-random pattern, so that stalls land on every word position. The bench judges the result in three ways. The cycle after the final handshake must show an idle output and a ready input. The waiting command must start its own packet one cycle later. Every word of both packets must match the scoreboard, with no field taken from the waiting command too early.

// File: rtl/mwr_pkg.sv
package mwr_pkg;

    localparam int ADDR_W    = 64;
    localparam int WORD_W    = 32;
    localparam int BE_W      = WORD_W / 8;
    localparam int RID_W     = 16;
    localparam int TAG_W     = 8;
    localparam int LEN_W     = 10;
    localparam int TYPE_W    = 5;
    localparam int FMT_W     = 2;
    localparam int HDR_SHORT = 3;
    localparam int HDR_LONG  = 4;
    localparam int PKT_MAX   = HDR_LONG + 1;
    localparam int IDX_W     = $clog2(PKT_MAX);
    localparam int PAD_W     = WORD_W - 1 - FMT_W - TYPE_W - LEN_W;

    localparam logic [FMT_W-1:0]  FMT_SHORT_DATA = 2'b10;
    localparam logic [FMT_W-1:0]  FMT_LONG_DATA  = 2'b11;
    localparam logic [TYPE_W-1:0] TYPE_MEM_WR    = 5'b00000;
    localparam logic [LEN_W-1:0]  PAYLOAD_DW     = LEN_W'(1);
    localparam logic [WORD_W-1:0] DW_ALIGN_MASK  = ~WORD_W'(3);

    typedef enum logic [2:0] {
        WK_HDR0,
        WK_HDR1,
        WK_ADDR_HI,
        WK_ADDR_LO,
        WK_DATA
    } word_kind_t;

    typedef struct packed {
        logic                long_fmt;
        logic [ADDR_W-1:0]   addr;
        logic [WORD_W-1:0]   data;
        logic [BE_W-1:0]     be;
    } held_cmd_t;

    function automatic logic needs_long(input logic [ADDR_W-1:0] a);
        return |a[ADDR_W-1:WORD_W];
    endfunction

    function automatic logic [IDX_W-1:0] final_index(input logic long_fmt);
        return long_fmt ? IDX_W'(HDR_LONG) : IDX_W'(HDR_SHORT);
    endfunction

    function automatic word_kind_t kind_at(input logic [IDX_W-1:0] idx,
                                           input logic long_fmt);
        word_kind_t k;
        case (idx)
            IDX_W'(0): k = WK_HDR0;
            IDX_W'(1): k = WK_HDR1;
            IDX_W'(2): k = long_fmt ? WK_ADDR_HI : WK_ADDR_LO;
            IDX_W'(3): k = long_fmt ? WK_ADDR_LO : WK_DATA;
            default:   k = WK_DATA;
        endcase
        return k;
    endfunction

    function automatic logic [WORD_W-1:0] make_hdr0(input logic long_fmt);
        return {1'b0,
                long_fmt ? FMT_LONG_DATA : FMT_SHORT_DATA,
                TYPE_MEM_WR,
                {PAD_W{1'b0}},
                PAYLOAD_DW};
    endfunction

    function automatic logic [WORD_W-1:0] make_hdr1(input logic [RID_W-1:0] rid,
                                                    input logic [TAG_W-1:0] tag,
                                                    input logic [BE_W-1:0]  first_be);
        return {rid, tag, {BE_W{1'b0}}, first_be};
    endfunction

endpackage

// File: rtl/mwr_cmd_hold.sv
module mwr_cmd_hold
    import mwr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [WORD_W-1:0]   data,
    input  logic [BE_W-1:0]     be,
    output held_cmd_t           held
);

    held_cmd_t held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (load) begin
            held_q.long_fmt <= needs_long(addr);
            held_q.addr     <= addr;
            held_q.data     <= data;
            held_q.be       <= be;
        end
    end

    assign held = held_q;

endmodule

// File: rtl/mwr_beat_seq.sv
module mwr_beat_seq
    import mwr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             long_fmt,
    input  logic             out_ready,
    output logic             busy,
    output word_kind_t       kind,
    output logic [TAG_W-1:0] tag
);

    logic             busy_q;
    logic [IDX_W-1:0] idx_q;
    logic [TAG_W-1:0] tag_q;
    logic             beat_taken;
    logic             at_final;

    assign beat_taken = busy_q && out_ready;
    assign at_final   = (idx_q == final_index(long_fmt));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
        end else if (load) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
        end else if (beat_taken) begin
            if (at_final) begin
                busy_q <= 1'b0;
                idx_q  <= '0;
            end else begin
                idx_q  <= idx_q + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q <= '0;
        end else if (beat_taken && at_final) begin
            tag_q <= tag_q + TAG_W'(1);
        end
    end

    assign busy = busy_q;
    assign kind = kind_at(idx_q, long_fmt);
    assign tag  = tag_q;

endmodule

// File: rtl/mwr_word_mux.sv
module mwr_word_mux
    import mwr_pkg::*;
#(
    parameter logic [RID_W-1:0] REQ_ID = 16'h0100
) (
    input  held_cmd_t           held,
    input  word_kind_t          kind,
    input  logic [TAG_W-1:0]    tag,
    output logic [WORD_W-1:0]   word
);

    always_comb begin
        case (kind)
            WK_HDR0:    word = make_hdr0(held.long_fmt);
            WK_HDR1:    word = make_hdr1(REQ_ID, tag, held.be);
            WK_ADDR_HI: word = held.addr[ADDR_W-1:WORD_W];
            WK_ADDR_LO: word = held.addr[WORD_W-1:0] & DW_ALIGN_MASK;
            default:    word = held.data;
        endcase
    end

endmodule

// File: rtl/mwr_packetizer.sv
module mwr_packetizer
    import mwr_pkg::*;
#(
    parameter logic [RID_W-1:0] REQ_ID = 16'h0100
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [ADDR_W-1:0]   cmd_addr,
    input  logic [WORD_W-1:0]   cmd_data,
    input  logic [BE_W-1:0]     cmd_be,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [WORD_W-1:0]   out_data,
    output logic                out_last
);

    held_cmd_t        held;
    word_kind_t       kind;
    logic [TAG_W-1:0] tag;
    logic             busy;
    logic             load;

    assign cmd_ready = !busy;
    assign load      = cmd_valid && !busy;

    mwr_cmd_hold u_hold (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .addr (cmd_addr),
        .data (cmd_data),
        .be   (cmd_be),
        .held (held)
    );

    mwr_beat_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .long_fmt  (held.long_fmt),
        .out_ready (out_ready),
        .busy      (busy),
        .kind      (kind),
        .tag       (tag)
    );

    mwr_word_mux #(.REQ_ID(REQ_ID)) u_mux (
        .held (held),
        .kind (kind),
        .tag  (tag),
        .word (out_data)
    );

    assign out_valid = busy;
    assign out_last  = busy && (kind == WK_DATA);

endmodule

// File: rtl/mwr_packetizer_chk.sv
module mwr_packetizer_chk (
    input logic        clk,
    input logic        rst,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic [63:0] cmd_addr,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_data,
    input logic        out_last
);

    logic [2:0] beat_cnt;
    logic       long_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_cnt  <= '0;
            long_seen <= 1'b0;
        end else begin
            if (out_valid && beat_cnt == 3'd0) begin
                long_seen <= out_data[29];
            end
            if (out_valid && out_ready) begin
                beat_cnt <= out_last ? 3'd0 : beat_cnt + 3'd1;
            end
        end
    end

    p_hold_stall_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    p_no_take_busy_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !cmd_ready);

    p_free_after_last_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> (!out_valid && cmd_ready));

    p_start_next_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> out_valid);

    p_short_fmt_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && cmd_addr[63:32] == 32'd0) |=> (out_data[30:29] == 2'b10));

    p_long_fmt_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && cmd_addr[63:32] != 32'd0) |=> (out_data[30:29] == 2'b11));

    p_one_payload_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_last) |-> (beat_cnt == (long_seen ? 3'd4 : 3'd3)));

endmodule

bind mwr_packetizer mwr_packetizer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_addr  (cmd_addr),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last)
);

// File: tb/mwr_packetizer_tb_top.sv
module mwr_packetizer_tb_top;

    localparam int          CLK_PERIOD = 10;
    localparam int          WATCHDOG   = 50000;
    localparam logic [15:0] RID        = 16'hBEEF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [63:0] cmd_addr = '0;
    logic [31:0] cmd_data = '0;
    logic [3:0]  cmd_be = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic        out_last;

    typedef struct {
        logic [31:0] w;
        logic        l;
        string       req;
    } exp_t;

    exp_t        sb_q[$];
    int          n_checks = 0;
    int          n_fail = 0;
    logic [7:0]  tb_tag = '0;
    int          ready_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit          run_mon = 1'b0;
    bit          finished = 1'b0;
    bit          stall_pend = 1'b0;
    logic [31:0] stall_w = '0;
    logic        stall_l = 1'b0;
    bit          last_pend = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mwr_packetizer #(.REQ_ID(RID)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data),
        .cmd_be    (cmd_be),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_last  (out_last)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic push_expected(input logic [63:0] a, input logic [31:0] d,
                                 input logic [3:0] b);
        exp_t e;
        bit   lng;
        lng = (a[63:32] != 32'd0);
        e.l = 1'b0;
        e.w = {1'b0, (lng ? 2'b11 : 2'b10), 5'b00000, 14'd0, 10'd1};
        e.req = "R5";
        sb_q.push_back(e);
        e.w = {RID, tb_tag, 4'b0000, b};
        e.req = "R6 R7";
        sb_q.push_back(e);
        if (lng) begin
            e.w = a[63:32];
            e.req = "R4";
            sb_q.push_back(e);
        end
        e.w = {a[31:2], 2'b00};
        e.req = lng ? "R4 R11" : "R3 R11";
        sb_q.push_back(e);
        e.w = d;
        e.l = 1'b1;
        e.req = "R8";
        sb_q.push_back(e);
        tb_tag = tb_tag + 8'd1;
    endtask

    task automatic send(input logic [63:0] a, input logic [31:0] d, input logic [3:0] b);
        @(posedge clk);
        #1;
        cmd_valid = 1'b1;
        cmd_addr  = a;
        cmd_data  = d;
        cmd_be    = b;
        forever begin
            @(negedge clk);
            if (cmd_ready) break;
        end
        push_expected(a, d, b);
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
        cmd_addr  = ~a;
        cmd_data  = ~d;
        cmd_be    = ~b;
        @(negedge clk);
        check(out_valid == 1'b1, "R10", "first word one cycle after accept",
              32'(out_valid), 32'd1);
    endtask

    task automatic drain();
        int guard;
        guard = 0;
        while ((sb_q.size() != 0 || out_valid) && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        check(sb_q.size() == 0, "R8", "scoreboard drained", 32'(sb_q.size()), 32'd0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = (ready_mode == 0) ? 1'b1 : (lfsr[0] | lfsr[3]);
        end
    end

    always @(negedge clk) begin
        if (!rst && run_mon) begin
            if (stall_pend) begin
                check(out_valid && out_data == stall_w && out_last == stall_l, "R9",
                      "word held during stall", out_data, stall_w);
            end
            if (last_pend) begin
                check(!out_valid && cmd_ready, "R10", "idle after last word",
                      {30'd0, out_valid, cmd_ready}, 32'd1);
            end
            stall_pend = out_valid && !out_ready;
            stall_w    = out_data;
            stall_l    = out_last;
            last_pend  = 1'b0;
            if (out_valid) begin
                check(!cmd_ready, "R2", "no command taken while sending",
                      32'(cmd_ready), 32'd0);
            end
            if (out_valid && out_ready) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R8", "word with nothing expected", out_data, 32'd0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(out_data == e.w, e.req, "word value", out_data, e.w);
                    check(out_last == e.l, "R8", "last flag", 32'(out_last), 32'(e.l));
                end
                last_pend = out_last;
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        check(1'b0, "WATCHDOG", "run did not complete", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!out_valid && !out_last && cmd_ready, "R1", "outputs during reset",
              {29'd0, out_valid, out_last, cmd_ready}, 32'd1);
        @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid && !out_last && cmd_ready, "R1", "outputs after reset",
              {29'd0, out_valid, out_last, cmd_ready}, 32'd1);
        run_mon = 1'b1;

        ready_mode = 0;
        send(64'h0000_0000_1234_5678, 32'hDEAD_BEEF, 4'hF);
        send(64'h0000_0001_0000_0000, 32'h0102_0304, 4'h3);
        send(64'h0000_0000_FFFF_FFFF, 32'hCAFE_F00D, 4'h8);
        send(64'hFFFF_FFFF_FFFF_FFFF, 32'h5555_AAAA, 4'h1);
        send(64'h0000_0000_0000_0001, 32'h0000_0000, 4'h0);
        drain();

        ready_mode = 1;
        for (int i = 0; i < 40; i++) begin
            logic [63:0] a;
            a = {(i % 3 == 0) ? 32'd0 : {lfsr, lfsr ^ 16'h1357}, lfsr, 16'(i * 97 + 3)};
            send(a, {lfsr, 16'(i)}, 4'(i));
        end
        drain();

        ready_mode = 0;
        for (int i = 0; i < 230; i++) begin
            send({32'(i & 1), 32'(i * 4 + 2)}, 32'(i), 4'hC);
        end
        drain();

        ready_mode = 1;
        send(64'h0000_0000_0000_0010, 32'hABCD_0001, 4'h5);
        send(64'h8000_0000_0000_0020, 32'hABCD_0002, 4'hA);
        drain();

        repeat (3) @(posedge clk);
        finish_run();
    end

endmodule